// File: doc/BRIEF.md
# Grouped Maskable Interrupt Aggregator

This block gathers level-sensitive interrupt sources into five groups of up to 32 lines each. Every group has a read-only pending register and a read/write mask register. A mask bit of 1 blocks its source. Each group raises its own CPU interrupt line whenever it has at least one valid, unmasked pending bit. A registered dispatch vector always names the one source that software should service next.

Each group has a fixed valid-bit pattern, and bits outside that pattern can never become pending. The highest group carries fourteen general-purpose pins in its low bits. Each pin has a selectable active level and a sticky status bit. Software clears a status bit either by writing the status register or by masking that source.

Software reaches every register through a word-addressed bus. Reads return data one cycle after the read strobe.

Top module: `irq_group_aggregator`

## Requirements
- R1: After reset every mask register equals its group's valid pattern: group 0 0x0000EFFF, group 1 0x00001FFF, group 2 0x00000007, group 3 0x0003FFFF, group 4 0xFFFFFFFF. Also after reset all CPU lines are low, vec_valid is 0, GPIO polarity reads 0x3FFF and GPIO status reads 0.
- R2: The word address is window*4 + offset. For windows 0 to 4 (the groups), offset 0 is pending and is read-only, so writes to it are ignored. Offset 2 is mask. bus_rdata holds the addressed register one cycle after bus_rd.
- R3: A mask bit of 1 blocks its source and 0 passes it. The mask stores only valid bits. Pending and mask read 0 in every bit outside the group's valid pattern.
- R4: Group g drives cpu_irq[g+2] combinationally, high when pending AND NOT mask is nonzero. cpu_irq[0], cpu_irq[1] and cpu_irq[7] stay 0.
- R5: One clock after the inputs settle, vec_num = group*32 + bit. The group is the highest one with an active line, and the bit is the highest unmasked pending bit in that group.
- R6: vec_valid is registered alongside vec_num, and it is 0 when no group line was active.
- R7: Window 5, offset 0 (word 20) is GPIO polarity. A 1 in bit i makes pin i active-high, and a 0 makes it active-low. Status bit i sets on the clock after pin i is at its active level, and it stays set after the pin goes inactive.
- R8: Window 5, offset 1 (word 21) is GPIO status. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. A clear takes priority in its own cycle, and the bit sets again on the next cycle if the pin is still active.
- R9: Group 4 pending bits 13:0 are the GPIO status bits. A write to the group 4 mask that stores a 1 in bit i (i < 14) clears GPIO status bit i.
- R10: Group 4 pending bits 31:14 follow src_in bits 159:142. src_in bits 141:128 have no effect.
- R11: Sources other than the GPIO pins are active-high levels and are not latched. Once a source drops, its pending bit reads 0 and its line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| src_in | input | 160 | Sources, group g at bits g*32+31 : g*32 |
| gpio_pin | input | 14 | General-purpose interrupt pins |
| cpu_irq | output | 8 | CPU interrupt lines, group g on line g+2 |
| vec_num | output | 8 | Dispatch vector, group*32 + bit |
| vec_valid | output | 1 | Dispatch vector valid |

## Verification
The bench drives sources that sit only in invalid bit positions, such as group 0 bit 12. A design that ignored the valid patterns would raise a line there. It also compares vectors in which both a lower group and a lower bit are active: a priority encoder that scanned in the wrong direction would report bit 0 or group 0. The GPIO checks cover stickiness after the pin drops, the level re-setting a bit right after a clear, active-low polarity, and clearing by masking. A design that dropped any of these would either lose an interrupt or keep re-raising line 6 after a mask and unmask.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int NGRP      = 5;
  localparam int SRC_W     = 32;
  localparam int GPIO_N    = 14;
  localparam int GPIO_GRP  = 4;
  localparam int LINE_BASE = 2;
  localparam int CPU_LINES = 8;
  localparam int GRP_W     = $clog2(NGRP);
  localparam int BIT_W     = $clog2(SRC_W);
  localparam int VEC_W     = GRP_W + BIT_W;
  localparam int TOT_W     = NGRP * SRC_W;

  // valid-bit pattern of each group
  function automatic logic [SRC_W-1:0] grp_valid(input int g);
    case (g)
      0:       return 32'h0000_EFFF;
      1:       return 32'h0000_1FFF;
      2:       return 32'h0000_0007;
      3:       return 32'h0003_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // index of the most significant set bit (0 when none)
  function automatic logic [BIT_W-1:0] top_bit(input logic [SRC_W-1:0] v);
    logic [BIT_W-1:0] r;
    r = '0;
    for (int i = 0; i < SRC_W; i++)
      if (v[i]) r = BIT_W'(i);
    return r;
  endfunction

  function automatic logic [GRP_W-1:0] top_grp(input logic [NGRP-1:0] v);
    logic [GRP_W-1:0] r;
    r = '0;
    for (int i = 0; i < NGRP; i++)
      if (v[i]) r = GRP_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irqagg_group.sv
module irqagg_group
  import irqagg_pkg::*;
#(
  parameter int GIDX = 0,
  parameter int W    = SRC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] eff,
  output logic         line
);
  localparam logic [W-1:0] VALID = W'(grp_valid(GIDX));

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= VALID;
    else if (mask_we) mask_q <= mask_wdata & VALID;
  end

  assign pend = raw & VALID;
  assign eff  = pend & ~mask_q;
  assign line = |eff;

  // R2: the mask only changes through a bus write
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  // R4: a fully masked group keeps its line low
  a_r4_line_off_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == VALID) |-> !line);
endmodule

// File: rtl/irqagg_gpio.sv
module irqagg_gpio #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  input  logic         pol_we,
  input  logic [N-1:0] pol_wdata,
  input  logic         stat_we,
  input  logic [N-1:0] stat_wdata,
  input  logic         mclr_we,
  input  logic [N-1:0] mclr_data,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] stat_q
);
  logic [N-1:0] hit;
  logic [N-1:0] clr;
  logic         past_ok;

  assign hit = ~(pin ^ pol_q);
  assign clr = (stat_we ? ~stat_wdata : '0) | (mclr_we ? mclr_data : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q   <= '1;
      stat_q  <= '0;
      past_ok <= 1'b0;
    end else begin
      if (pol_we) pol_q <= pol_wdata;
      stat_q  <= (stat_q | hit) & ~clr;
      past_ok <= 1'b1;
    end
  end

  // R8: a requested clear wins over a set in the same cycle
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((stat_q & $past(clr)) == '0));

  // R7: status bits only fall on a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(stat_q) & ~$past(clr) & ~stat_q) == '0));
endmodule

// File: rtl/irqagg_dispatch.sv
module irqagg_dispatch
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOT_W-1:0] eff_flat,
  input  logic [NGRP-1:0]  lines,
  output logic [VEC_W-1:0] vec_q,
  output logic             vec_valid_q
);
  localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

  logic [GRP_W-1:0] gsel;
  logic [BIT_W-1:0] bsel;
  logic [SRC_W-1:0] gword;
  logic             past_ok;

  always_comb begin
    gsel  = top_grp(lines);
    gword = eff_flat[int'(gsel)*SRC_W +: SRC_W];
    bsel  = top_bit(gword);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
      past_ok     <= 1'b0;
    end else begin
      vec_q       <= {gsel, bsel};
      vec_valid_q <= |lines;
      past_ok     <= 1'b1;
    end
  end

  // R6: valid follows the group lines one cycle later
  a_r6_valid_tracks_lines: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (vec_valid_q == $past(|lines)));

  // R5: the chosen source was active and nothing above it was
  a_r5_top_index: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && vec_valid_q) |-> (($past(eff_flat) >> vec_q) == ONE));
endmodule

// File: rtl/irq_group_aggregator.sv
module irq_group_aggregator
  import irqagg_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int STRIDE   = 4,
  parameter int PEND_OFF = 0,
  parameter int MASK_OFF = 2,
  parameter int POL_OFF  = 0,
  parameter int STAT_OFF = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [SRC_W-1:0]     bus_wdata,
  output logic [SRC_W-1:0]     bus_rdata,
  input  logic [TOT_W-1:0]     src_in,
  input  logic [GPIO_N-1:0]    gpio_pin,
  output logic [CPU_LINES-1:0] cpu_irq,
  output logic [VEC_W-1:0]     vec_num,
  output logic                 vec_valid
);
  localparam int OFF_W = $clog2(STRIDE);
  localparam int WIN_W = ADDR_W - OFF_W;
  localparam int GPIO_WIN = NGRP;

  logic [WIN_W-1:0] win;
  logic [OFF_W-1:0] off;
  logic [SRC_W-1:0] pend_arr [NGRP];
  logic [SRC_W-1:0] mask_arr [NGRP];
  logic [TOT_W-1:0] eff_flat;
  logic [NGRP-1:0]  lines;
  logic [NGRP-1:0]  mask_we;
  logic [GPIO_N-1:0] pol_q, stat_q;
  logic             pol_we, stat_we;
  logic [SRC_W-1:0] rd_val;

  assign win = bus_addr[ADDR_W-1:OFF_W];
  assign off = bus_addr[OFF_W-1:0];
  assign pol_we  = bus_wr && (win == WIN_W'(GPIO_WIN)) && (off == OFF_W'(POL_OFF));
  assign stat_we = bus_wr && (win == WIN_W'(GPIO_WIN)) && (off == OFF_W'(STAT_OFF));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SRC_W-1:0] raw;
    logic [SRC_W-1:0] eff;
    if (g == GPIO_GRP) begin : g_gpio_raw
      assign raw = {src_in[g*SRC_W + GPIO_N +: SRC_W-GPIO_N], stat_q};
    end else begin : g_plain_raw
      assign raw = src_in[g*SRC_W +: SRC_W];
    end
    assign mask_we[g] = bus_wr && (win == WIN_W'(g)) && (off == OFF_W'(MASK_OFF));

    irqagg_group #(.GIDX(g), .W(SRC_W)) u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (raw),
      .mask_we    (mask_we[g]),
      .mask_wdata (bus_wdata),
      .pend       (pend_arr[g]),
      .mask_q     (mask_arr[g]),
      .eff        (eff),
      .line       (lines[g])
    );
    assign eff_flat[g*SRC_W +: SRC_W] = eff;
  end

  irqagg_gpio #(.N(GPIO_N)) u_gpio (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin        (gpio_pin),
    .pol_we     (pol_we),
    .pol_wdata  (bus_wdata[GPIO_N-1:0]),
    .stat_we    (stat_we),
    .stat_wdata (bus_wdata[GPIO_N-1:0]),
    .mclr_we    (mask_we[GPIO_GRP]),
    .mclr_data  (bus_wdata[GPIO_N-1:0]),
    .pol_q      (pol_q),
    .stat_q     (stat_q)
  );

  irqagg_dispatch u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .eff_flat    (eff_flat),
    .lines       (lines),
    .vec_q       (vec_num),
    .vec_valid_q (vec_valid)
  );

  always_comb begin
    cpu_irq = '0;
    cpu_irq[LINE_BASE +: NGRP] = lines;
  end

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (win == WIN_W'(g)) begin
        if (off == OFF_W'(PEND_OFF)) rd_val = pend_arr[g];
        if (off == OFF_W'(MASK_OFF)) rd_val = mask_arr[g];
      end
    end
    if (win == WIN_W'(GPIO_WIN)) begin
      if (off == OFF_W'(POL_OFF))  rd_val = {{(SRC_W-GPIO_N){1'b0}}, pol_q};
      if (off == OFF_W'(STAT_OFF)) rd_val = {{(SRC_W-GPIO_N){1'b0}}, stat_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: tb/irq_group_aggregator_tb.sv
`timescale 1ns/1ps
module irq_group_aggregator_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [159:0] src_in = '0;
  logic [13:0]  gpio_pin = '0;
  logic [7:0]   cpu_irq;
  logic [7:0]   vec_num;
  logic         vec_valid;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_group_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .gpio_pin(gpio_pin), .cpu_irq(cpu_irq),
    .vec_num(vec_num), .vec_valid(vec_valid));

  typedef struct packed {
    logic [4:0][31:0] m;
    logic [4:0][31:0] s;
    logic [7:0]       irq;
    logic [7:0]       vec;
    logic             v;
  } tv_t;

  localparam tv_t TBL [8] = '{
    '{m:{32'h0,32'h0,32'h0,32'h0,32'h0}, s:{32'h0,32'h0,32'h0,32'h0,32'h0}, irq:8'h00, vec:8'd0, v:1'b0},
    '{m:{32'h0,32'h0,32'h0,32'h0,32'h0}, s:{32'h0,32'h0,32'h0,32'h0,32'h1000}, irq:8'h00, vec:8'd0, v:1'b0},
    '{m:{32'h0,32'h0,32'h0,32'h0,32'h0}, s:{32'h0,32'h0,32'h5,32'h0,32'h8001}, irq:8'h14, vec:8'd66, v:1'b1},
    '{m:{32'h0,32'h0,32'h4,32'h0,32'h0}, s:{32'h0,32'h0,32'h5,32'h0,32'h8001}, irq:8'h14, vec:8'd64, v:1'b1},
    '{m:{32'h0,32'h0,32'h7,32'h0,32'h0}, s:{32'h0,32'h0,32'h5,32'h0,32'h8001}, irq:8'h04, vec:8'd15, v:1'b1},
    '{m:{32'h0,32'h0,32'h0,32'h0,32'h0}, s:{32'h80004000,32'hFFFFFFFF,32'h0,32'hFFFF,32'h0}, irq:8'h68, vec:8'd159, v:1'b1},
    '{m:{32'h80000000,32'h0,32'h0,32'h0,32'h0}, s:{32'h80004000,32'hFFFFFFFF,32'h0,32'hFFFF,32'h0}, irq:8'h68, vec:8'd142, v:1'b1},
    '{m:{32'hFFFFFFFF,32'h20000,32'h0,32'h0,32'h0}, s:{32'h80004000,32'hFFFFFFFF,32'h0,32'hFFFF,32'h0}, irq:8'h28, vec:8'd112, v:1'b1}
  };

  localparam logic [31:0] VALIDS [5] = '{32'h0000EFFF, 32'h00001FFF, 32'h00000007,
                                         32'h0003FFFF, 32'hFFFFFFFF};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 cpu_irq", {24'h0, cpu_irq}, 32'h0);
    chk("R1 vec_valid", {31'h0, vec_valid}, 32'h0);
    for (int g = 0; g < 5; g++) begin
      rd(5'(g*4 + 2), d);
      chk("R1 mask reset", d, VALIDS[g]);
    end
    rd(5'd20, d); chk("R1 polarity reset", d, 32'h3FFF);
    rd(5'd21, d); chk("R1 status reset", d, 32'h0);

    // table: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      for (int g = 0; g < 5; g++) wr(5'(g*4 + 2), TBL[i].m[g]);
      src_in = TBL[i].s;
      idle(2);
      chk("R4 table cpu_irq", {24'h0, cpu_irq}, {24'h0, TBL[i].irq});
      chk("R6 table vec_valid", {31'h0, vec_valid}, {31'h0, TBL[i].v});
      if (TBL[i].v) chk("R5 table vec_num", {24'h0, vec_num}, {24'h0, TBL[i].vec});
    end

    src_in = '0;
    for (int g = 0; g < 5; g++) wr(5'(g*4 + 2), 32'h0);

    // R2 pending read-only, R3 invalid bits read zero
    src_in[31:0] = 32'hFFFFFFFF;
    wr(5'd0, 32'h0);
    rd(5'd0, d); chk("R2 pending write ignored", d, 32'h0000EFFF);
    wr(5'd10, 32'hFFFFFFFF);
    rd(5'd10, d); chk("R3 mask stores valid bits", d, 32'h7);
    wr(5'd10, 32'h0);
    src_in = '0;

    // R11 level-following sources
    src_in[32] = 1'b1;
    idle(2);
    chk("R11 line on", {31'h0, cpu_irq[3]}, 32'h1);
    chk("R5 vec group1 bit0", {24'h0, vec_num}, 32'd32);
    src_in[32] = 1'b0;
    idle(1);
    chk("R11 line off", {31'h0, cpu_irq[3]}, 32'h0);
    rd(5'd4, d); chk("R11 pending drops", d, 32'h0);

    // R10 group 4 low bits not from src_in
    src_in[141:128] = 14'h3FFF;
    idle(2);
    chk("R10 line6 low", {31'h0, cpu_irq[6]}, 32'h0);
    rd(5'd16, d); chk("R10 pending low bits", d, 32'h0);
    src_in = '0;

    // R7 active-high pin, sticky status
    gpio_pin[3] = 1'b1;
    idle(3);
    chk("R7 line6 from pin", {31'h0, cpu_irq[6]}, 32'h1);
    chk("R7 vec pin3", {24'h0, vec_num}, 32'd131);
    gpio_pin[3] = 1'b0;
    idle(2);
    chk("R7 sticky line", {31'h0, cpu_irq[6]}, 32'h1);
    rd(5'd21, d); chk("R7 sticky status", d, 32'h8);

    // R8 write-zero clear, active-low polarity
    wr(5'd21, 32'h0);
    rd(5'd21, d); chk("R8 status cleared", d, 32'h0);
    chk("R8 line6 low after clear", {31'h0, cpu_irq[6]}, 32'h0);
    wr(5'd20, 32'h3FDF);
    idle(2);
    rd(5'd21, d); chk("R7 active-low sets", d, 32'h20);
    wr(5'd20, 32'h3FFF);
    wr(5'd21, 32'h0);
    rd(5'd21, d); chk("R8 clear after restore", d, 32'h0);
    gpio_pin[0] = 1'b1;
    idle(2);
    wr(5'd21, 32'h0);
    rd(5'd21, d); chk("R8 level re-sets after clear", d, 32'h1);
    gpio_pin[0] = 1'b0;
    wr(5'd21, 32'h3FFE);
    rd(5'd21, d); chk("R8 write-one keeps others", d, 32'h0);

    // R9 masking clears status
    gpio_pin[7] = 1'b1;
    idle(2);
    gpio_pin[7] = 1'b0;
    rd(5'd21, d); chk("R9 status before mask", d, 32'h80);
    wr(5'd18, 32'h80);
    rd(5'd21, d); chk("R9 mask clears status", d, 32'h0);
    wr(5'd18, 32'h0);
    idle(2);
    chk("R9 line6 stays low after unmask", {31'h0, cpu_irq[6]}, 32'h0);
    chk("R6 idle vec_valid", {31'h0, vec_valid}, 32'h0);
    chk("R4 spare lines low", {29'h0, cpu_irq[7], cpu_irq[1:0]}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule